// File: doc/BRIEF.md
# Remote DMA Port with Interrupt Status

This block is the host-facing side of a packet buffer inside an Ethernet controller. Software programs a 16-bit buffer pointer and a 16-bit transfer length through a small 8-bit register window. It then moves bytes through a separate data port. Each data-port access reads or writes the on-chip byte RAM at the pointer, advances the pointer and consumes the length. The pointer folds back inside a receive ring bounded by a first page and a last page. When the length runs out, a completion flag is raised.

The register window is paged. A command register, visible in every page, holds a stop bit, a 3-bit DMA command and a 2-bit page selector. Page 0 holds the programming registers. Page 1 reads back the ring bounds and the interrupt mask. A status register collects the completion flag, a power-up flag and event pulses from the rest of the controller. Software clears it by writing ones. One interrupt line is raised whenever an enabled status bit in positions 6..0 is set.

Top module: `rdma_port`

## Requirements
- R1: After reset the command register reads 0x22, status reads 0x80, mask reads 0x00, pointer and length read 0, and the interrupt line is low.
- R2: The command register sits at offset 0 in every page, with stop in bit 0, the DMA command in bits 5:3 (1 read, 2 write, 3 send, 4 abort) and the page in bits 7:6. Writing it with bit 0 clear clears status bit 7.
- R3: Writing command 1 or 2 while the remaining length is 0 sets status bit 6 (done) at the next edge.
- R4: In page 0, offsets 4/5 load the low/high pointer byte and offsets 6/7 load the low/high length byte. Reads of the same offsets return the current pointer and the remaining length.
- R5: A data access moves N bytes (N=1 narrow, N=2 wide; low byte at the pointer, high byte at pointer+1) and advances the pointer by N.
- R6: If the advanced pointer equals last page × 256 (offset 2), it is reloaded with first page × 256 (offset 1).
- R7: If the remaining length is at most N, it becomes 0 and status bit 6 is set; otherwise it drops by N.
- R8: A data write while the length is 0 changes neither the RAM, the pointer nor the length.
- R9: Read data appears on the data output on the cycle after the read strobe; for a narrow read the high byte is 0.
- R10: Writing status (offset 3, page 0) clears each bit 6..0 written as 1 and leaves bit 7 alone. An event input set in the same cycle wins over the clear.
- R11: The interrupt line is high exactly when status AND mask is non-zero in bits 6..0. Bit 7 never raises it.
- R12: Page 1 reads first page, last page and mask at offsets 1, 2 and 8. Writes in page 1 to offsets other than 0 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 4 | Register offset |
| regWrData | input | 8 | Register write byte |
| regRdData | output | 8 | Register read byte (combinational) |
| dataRd | input | 1 | Data-port read strobe |
| dataWr | input | 1 | Data-port write strobe |
| dataWide | input | 1 | Data access moves two bytes |
| dataWrVal | input | 16 | Data-port write value, low byte first |
| dataRdVal | output | 16 | Data-port read value |
| evtSet | input | 7 | Status set pulses from other units |
| irq | output | 1 | Interrupt request |

## Verification
The properties assume that a register write and a data-port strobe never share a cycle. They also assume that read and write strobes are never raised together, because the block resolves those overlaps by priority and the checks do not follow that path. The stimulus issues one operation per clock and drops every strobe before the next one starts. Event pulses are kept apart from completion events, except in one case that deliberately overlaps an event with a status clear. Wide accesses that cross the ring end start on an even pointer with an even last-page boundary, so the advanced pointer lands exactly on the boundary.

// File: rtl/rdma_pkg.sv
package rdma_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;
  localparam int LANES  = WORD_W / BYTE_W;

  localparam logic [3:0] OFS_CMD     = 4'd0;
  localparam logic [3:0] OFS_RING_LO = 4'd1;
  localparam logic [3:0] OFS_RING_HI = 4'd2;
  localparam logic [3:0] OFS_STAT    = 4'd3;
  localparam logic [3:0] OFS_PTR_L   = 4'd4;
  localparam logic [3:0] OFS_PTR_H   = 4'd5;
  localparam logic [3:0] OFS_LEN_L   = 4'd6;
  localparam logic [3:0] OFS_LEN_H   = 4'd7;
  localparam logic [3:0] OFS_MASK    = 4'd8;

  localparam logic [BYTE_W-1:0] CMD_INIT = 8'h22;
  localparam logic [BYTE_W-1:0] STAT_INIT = 8'h80;
  localparam logic [2:0] DMA_RD = 3'd1;
  localparam logic [2:0] DMA_WR = 3'd2;
  localparam int DONE_BIT = 6;
  localparam int PWR_BIT  = 7;

  typedef struct packed {
    logic ldPtrLo;
    logic ldPtrHi;
    logic ldLenLo;
    logic ldLenHi;
    logic step;
    logic wide;
    logic isWr;
    logic [BYTE_W-1:0] byteVal;
  } dmaCtl_t;
endpackage

// File: rtl/rdma_dpath.sv
module rdma_dpath
  import rdma_pkg::*;
#(
  parameter int MEM_AW = 10
) (
  input  logic                clk,
  input  logic                rstN,
  input  dmaCtl_t             ctl,
  input  logic [BYTE_W-1:0]   startPg,
  input  logic [BYTE_W-1:0]   stopPg,
  input  logic [WORD_W-1:0]   dataWrVal,
  output logic [WORD_W-1:0]   currAddr,
  output logic [WORD_W-1:0]   remCnt,
  output logic                cntZero,
  output logic                doneEvt,
  output logic [WORD_W-1:0]   dataRdVal
);
  localparam int DEPTH = 1 << MEM_AW;

  logic [BYTE_W-1:0] mem [DEPTH];
  logic [WORD_W-1:0] ptrQ, lenQ;
  logic [WORD_W-1:0] stepN, ptrAdv, ptrNext;
  logic [MEM_AW-1:0] laneIdx [LANES];
  logic [LANES-1:0]  laneOn;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign laneIdx[l] = MEM_AW'(ptrQ + WORD_W'(l));
    assign laneOn[l]  = (l == 0) || ctl.wide;
  end

  always_comb begin
    stepN   = ctl.wide ? WORD_W'(LANES) : WORD_W'(1);
    ptrAdv  = ptrQ + stepN;
    ptrNext = (ptrAdv == {stopPg, 8'h00}) ? {startPg, 8'h00} : ptrAdv;
  end

  assign doneEvt  = ctl.step && (lenQ <= stepN);
  assign cntZero  = (lenQ == '0);
  assign currAddr = ptrQ;
  assign remCnt   = lenQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptrQ <= '0;
      lenQ <= '0;
    end else if (ctl.step) begin
      ptrQ <= ptrNext;
      lenQ <= (lenQ <= stepN) ? '0 : lenQ - stepN;
    end else begin
      if (ctl.ldPtrLo) ptrQ[BYTE_W-1:0]      <= ctl.byteVal;
      if (ctl.ldPtrHi) ptrQ[WORD_W-1:BYTE_W] <= ctl.byteVal;
      if (ctl.ldLenLo) lenQ[BYTE_W-1:0]      <= ctl.byteVal;
      if (ctl.ldLenHi) lenQ[WORD_W-1:BYTE_W] <= ctl.byteVal;
    end
  end

  always_ff @(posedge clk) begin
    for (int l = 0; l < LANES; l++) begin
      if (ctl.step && ctl.isWr && laneOn[l])
        mem[laneIdx[l]] <= dataWrVal[l*BYTE_W +: BYTE_W];
      if (ctl.step && !ctl.isWr)
        dataRdVal[l*BYTE_W +: BYTE_W] <= laneOn[l] ? mem[laneIdx[l]] : '0;
    end
  end
endmodule

// File: rtl/rdma_ctrl.sv
module rdma_ctrl
  import rdma_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWr,
  input  logic [3:0]          regAddr,
  input  logic [BYTE_W-1:0]   regWrData,
  input  logic                dataRd,
  input  logic                dataWr,
  input  logic                dataWide,
  input  logic [6:0]          evtSet,
  input  logic                cntZero,
  input  logic                doneEvt,
  input  logic [WORD_W-1:0]   currAddr,
  input  logic [WORD_W-1:0]   remCnt,
  output dmaCtl_t             ctl,
  output logic [BYTE_W-1:0]   regRdData,
  output logic [BYTE_W-1:0]   cmdQ,
  output logic [BYTE_W-1:0]   startPg,
  output logic [BYTE_W-1:0]   stopPg,
  output logic [BYTE_W-1:0]   isrQ,
  output logic [BYTE_W-1:0]   imrQ,
  output logic                irq
);
  logic [1:0] page;
  logic wrCmd, wrP0, cmdKick;
  logic [BYTE_W-1:0] isrNext;

  assign page    = cmdQ[7:6];
  assign wrCmd   = regWr && (regAddr == OFS_CMD);
  assign wrP0    = regWr && (page == 2'd0);
  assign cmdKick = wrCmd && cntZero &&
                   ((regWrData[5:3] == DMA_RD) || (regWrData[5:3] == DMA_WR));

  always_comb begin
    ctl         = '0;
    ctl.ldPtrLo = wrP0 && (regAddr == OFS_PTR_L);
    ctl.ldPtrHi = wrP0 && (regAddr == OFS_PTR_H);
    ctl.ldLenLo = wrP0 && (regAddr == OFS_LEN_L);
    ctl.ldLenHi = wrP0 && (regAddr == OFS_LEN_H);
    ctl.byteVal = regWrData;
    ctl.step    = !regWr && (dataRd || (dataWr && !cntZero));
    ctl.wide    = dataWide;
    ctl.isWr    = dataWr && !dataRd;
  end

  always_comb begin
    isrNext = isrQ;
    if (wrP0 && (regAddr == OFS_STAT))
      isrNext[6:0] = isrNext[6:0] & ~regWrData[6:0];
    if (wrCmd && !regWrData[0])
      isrNext[PWR_BIT] = 1'b0;
    isrNext[6:0] = isrNext[6:0] | evtSet;
    if (doneEvt || cmdKick)
      isrNext[DONE_BIT] = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdQ    <= CMD_INIT;
      startPg <= '0;
      stopPg  <= '0;
      isrQ    <= STAT_INIT;
      imrQ    <= '0;
    end else begin
      isrQ <= isrNext;
      if (wrCmd) cmdQ <= regWrData;
      if (wrP0 && (regAddr == OFS_RING_LO)) startPg <= regWrData;
      if (wrP0 && (regAddr == OFS_RING_HI)) stopPg  <= regWrData;
      if (wrP0 && (regAddr == OFS_MASK))    imrQ    <= regWrData;
    end
  end

  assign irq = |(isrQ[6:0] & imrQ[6:0]);

  always_comb begin
    regRdData = '0;
    if (regAddr == OFS_CMD) begin
      regRdData = cmdQ;
    end else if (page == 2'd0) begin
      case (regAddr)
        OFS_STAT:  regRdData = isrQ;
        OFS_PTR_L: regRdData = currAddr[BYTE_W-1:0];
        OFS_PTR_H: regRdData = currAddr[WORD_W-1:BYTE_W];
        OFS_LEN_L: regRdData = remCnt[BYTE_W-1:0];
        OFS_LEN_H: regRdData = remCnt[WORD_W-1:BYTE_W];
        default:   regRdData = '0;
      endcase
    end else if (page == 2'd1) begin
      case (regAddr)
        OFS_RING_LO: regRdData = startPg;
        OFS_RING_HI: regRdData = stopPg;
        OFS_MASK:    regRdData = imrQ;
        default:     regRdData = '0;
      endcase
    end
  end
endmodule

// File: rtl/rdma_port.sv
module rdma_port
  import rdma_pkg::*;
#(
  parameter int MEM_AW = 10
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWr,
  input  logic [3:0]  regAddr,
  input  logic [7:0]  regWrData,
  output logic [7:0]  regRdData,
  input  logic        dataRd,
  input  logic        dataWr,
  input  logic        dataWide,
  input  logic [15:0] dataWrVal,
  output logic [15:0] dataRdVal,
  input  logic [6:0]  evtSet,
  output logic        irq
);
  dmaCtl_t ctl;
  logic [BYTE_W-1:0] cmdQ, startPg, stopPg, isrQ, imrQ;
  logic [WORD_W-1:0] currAddr, remCnt;
  logic cntZero, doneEvt;

  rdma_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWrData(regWrData), .dataRd(dataRd), .dataWr(dataWr),
    .dataWide(dataWide), .evtSet(evtSet), .cntZero(cntZero),
    .doneEvt(doneEvt), .currAddr(currAddr), .remCnt(remCnt), .ctl(ctl),
    .regRdData(regRdData), .cmdQ(cmdQ), .startPg(startPg), .stopPg(stopPg),
    .isrQ(isrQ), .imrQ(imrQ), .irq(irq)
  );

  rdma_dpath #(.MEM_AW(MEM_AW)) u_dpath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .startPg(startPg), .stopPg(stopPg),
    .dataWrVal(dataWrVal), .currAddr(currAddr), .remCnt(remCnt),
    .cntZero(cntZero), .doneEvt(doneEvt), .dataRdVal(dataRdVal)
  );
endmodule

// File: rtl/rdma_port_chk.sv
module rdma_port_chk (
  input logic        clk,
  input logic        rstN,
  input logic        regWr,
  input logic [3:0]  regAddr,
  input logic [7:0]  regWrData,
  input logic        dataRd,
  input logic        dataWr,
  input logic        dataWide,
  input logic [6:0]  evtSet,
  input logic        irq,
  input logic [15:0] currAddr,
  input logic [15:0] remCnt,
  input logic [7:0]  isrQ,
  input logic [7:0]  cmdQ,
  input logic [7:0]  startPg,
  input logic [7:0]  stopPg
);
  logic        stepC;
  logic [15:0] nC;
  assign stepC = !regWr && (dataRd || (dataWr && remCnt != 16'd0));
  assign nC    = dataWide ? 16'd2 : 16'd1;

  // R7
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stepC && remCnt > nC) |=> (remCnt == $past(remCnt) - $past(nC)));

  // R7
  cnt_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stepC && remCnt <= nC) |=> (remCnt == 16'd0 && isrQ[6]));

  // R6
  ring_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stepC && (currAddr + nC) == {stopPg, 8'h00}) |=> (currAddr == {startPg, 8'h00}));

  // R8
  idle_wr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!regWr && !dataRd && dataWr && remCnt == 16'd0) |=> ($stable(currAddr) && remCnt == 16'd0));

  // R3
  cmd_kick_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regAddr == 4'd0 && remCnt == 16'd0 &&
     (regWrData[5:3] == 3'd1 || regWrData[5:3] == 3'd2)) |=> isrQ[6]);

  // R10
  stat_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && cmdQ[7:6] == 2'd0 && regAddr == 4'd3 && evtSet == 7'd0)
    |=> ((isrQ[6:0] & $past(regWrData[6:0])) == 7'd0));

  // R11
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (isrQ[6:0] == 7'd0) |-> !irq);
endmodule

bind rdma_port rdma_port_chk u_chk (
  .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
  .regWrData(regWrData), .dataRd(dataRd), .dataWr(dataWr),
  .dataWide(dataWide), .evtSet(evtSet), .irq(irq), .currAddr(currAddr),
  .remCnt(remCnt), .isrQ(isrQ), .cmdQ(cmdQ), .startPg(startPg), .stopPg(stopPg)
);

// File: tb/sim_rdma_port.sv
module sim_rdma_port;
  logic        clk = 1'b0;
  logic        rstN;
  logic        regWr;
  logic [3:0]  regAddr;
  logic [7:0]  regWrData;
  logic [7:0]  regRdData;
  logic        dataRd, dataWr, dataWide;
  logic [15:0] dataWrVal, dataRdVal;
  logic [6:0]  evtSet;
  logic        irq;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  rdma_port u0 (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .dataRd(dataRd),
    .dataWr(dataWr), .dataWide(dataWide), .dataWrVal(dataWrVal),
    .dataRdVal(dataRdVal), .evtSet(evtSet), .irq(irq)
  );

  // behavioural reference model
  int mPtr, mLen, mIsr, mImr, mStart, mStop, mRdExp, mN, mIsrN;
  logic [7:0] mCmd;
  logic [7:0] mMem [int];
  bit mRdPend;

  always @(posedge clk) begin
    if (!rstN) begin
      mPtr = 0; mLen = 0; mIsr = 'h80; mImr = 0; mStart = 0; mStop = 0;
      mCmd = 8'h22; mRdPend = 0;
    end else begin
      mIsrN = mIsr;
      mRdPend = 0;
      if (regWr) begin
        if (regAddr == 4'd0) begin
          if (!regWrData[0]) mIsrN = mIsrN & ~'h80;
          if ((regWrData[5:3] == 3'd1 || regWrData[5:3] == 3'd2) && mLen == 0)
            mIsrN = mIsrN | 'h40;
          mCmd = regWrData;
        end else if (mCmd[7:6] == 2'd0) begin
          case (regAddr)
            4'd1: mStart = regWrData;
            4'd2: mStop = regWrData;
            4'd3: mIsrN = mIsrN & ~(int'(regWrData) & 'h7f);
            4'd4: mPtr = (mPtr & 'hff00) | regWrData;
            4'd5: mPtr = (mPtr & 'h00ff) | (int'(regWrData) << 8);
            4'd6: mLen = (mLen & 'hff00) | regWrData;
            4'd7: mLen = (mLen & 'h00ff) | (int'(regWrData) << 8);
            4'd8: mImr = regWrData;
            default: ;
          endcase
        end
      end else if (dataRd || (dataWr && mLen != 0)) begin
        mN = dataWide ? 2 : 1;
        if (dataRd) begin
          mRdExp = int'(mMem[mPtr]);
          if (dataWide) mRdExp = mRdExp | (int'(mMem[(mPtr + 1) & 'hffff]) << 8);
          mRdPend = 1;
        end else begin
          mMem[mPtr] = dataWrVal[7:0];
          if (dataWide) mMem[(mPtr + 1) & 'hffff] = dataWrVal[15:8];
        end
        mPtr = (mPtr + mN) & 'hffff;
        if (mPtr == (mStop << 8)) mPtr = mStart << 8;
        if (mLen <= mN) begin mLen = 0; mIsrN = mIsrN | 'h40; end
        else mLen = mLen - mN;
      end
      mIsrN = mIsrN | int'(evtSet);
      mIsr = mIsrN;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN) begin
      #2;
      chk("R11 irq vs model", int'(irq), int'(((mIsr & mImr) & 'h7f) != 0));
      if (mRdPend) chk("R9 read data vs model", int'(dataRdVal), mRdExp);
    end
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    regAddr = a; regWrData = d; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic chkReg(input string req, input logic [3:0] a, input int exp);
    regAddr = a;
    #1;
    chk(req, int'(regRdData), exp);
  endtask

  task automatic dw(input logic wide, input logic [15:0] v);
    dataWr = 1'b1; dataWide = wide; dataWrVal = v;
    @(negedge clk);
    dataWr = 1'b0;
  endtask

  task automatic dr(input logic wide);
    dataRd = 1'b1; dataWide = wide;
    @(negedge clk);
    dataRd = 1'b0;
    #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rstN = 1'b0; regWr = 0; regAddr = 0; regWrData = 0;
    dataRd = 0; dataWr = 0; dataWide = 0; dataWrVal = 0; evtSet = 0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    chkReg("R1 cmd", 4'd0, 'h22);
    chkReg("R1 status", 4'd3, 'h80);
    chkReg("R1 ptr lo", 4'd4, 0);
    chkReg("R1 ptr hi", 4'd5, 0);
    chkReg("R1 len lo", 4'd6, 0);
    chkReg("R1 len hi", 4'd7, 0);
    chk("R1 irq", int'(irq), 0);

    // R10 bit 7 untouched by clear; R11 bit 7 never interrupts
    wr(4'd3, 8'hFF);
    chkReg("R10 bit7 kept", 4'd3, 'h80);
    wr(4'd8, 8'hFF);
    #1 chk("R11 bit7 no irq", int'(irq), 0);

    // R2 command write with stop clear drops bit 7
    wr(4'd0, 8'h22);
    chkReg("R2 power flag cleared", 4'd3, 0);

    // R3 read command at zero length
    wr(4'd0, 8'h0A);
    chkReg("R3 immediate done", 4'd3, 'h40);
    chk("R11 irq on done", int'(irq), 1);
    wr(4'd3, 8'h40);
    chkReg("R10 clear done", 4'd3, 0);
    chk("R11 irq drops", int'(irq), 0);

    // R4 programming
    wr(4'd1, 8'h02); wr(4'd2, 8'h03);
    wr(4'd4, 8'h00); wr(4'd5, 8'h02);
    wr(4'd6, 8'h04); wr(4'd7, 8'h00);
    chkReg("R4 ptr lo", 4'd4, 'h00);
    chkReg("R4 ptr hi", 4'd5, 'h02);
    chkReg("R4 len lo", 4'd6, 'h04);
    wr(4'd0, 8'h12);
    chkReg("R3 no done with length", 4'd3, 0);

    // R5 R7 writes
    dw(1'b0, 16'h0011);
    chkReg("R5 ptr +1", 4'd4, 'h01);
    chkReg("R7 len -1", 4'd6, 'h03);
    dw(1'b0, 16'h0022);
    dw(1'b1, 16'h4433);
    chkReg("R5 ptr +2", 4'd4, 'h04);
    chkReg("R7 len zero", 4'd6, 0);
    chkReg("R7 done flag", 4'd3, 'h40);
    wr(4'd3, 8'h7F);

    // R8 write at zero length ignored
    wr(4'd4, 8'h00);
    dw(1'b0, 16'h0099);
    chkReg("R8 ptr unchanged", 4'd4, 'h00);
    chkReg("R8 len unchanged", 4'd6, 0);
    chkReg("R8 status unchanged", 4'd3, 0);

    // R9 reads
    wr(4'd6, 8'h03);
    wr(4'd0, 8'h0A);
    dr(1'b1);
    chk("R9 R8 wide read", int'(dataRdVal), 'h2211);
    dr(1'b0);
    chk("R9 narrow read", int'(dataRdVal), 'h0033);
    chkReg("R7 done after read", 4'd3, 'h40);
    wr(4'd3, 8'h7F);

    // R6 wrap
    wr(4'd4, 8'hFE); wr(4'd5, 8'h02);
    wr(4'd6, 8'h10);
    wr(4'd0, 8'h12);
    dw(1'b1, 16'hBBAA);
    chkReg("R6 wrap lo", 4'd4, 'h00);
    chkReg("R6 wrap hi", 4'd5, 'h02);
    chkReg("R7 len 0x0e", 4'd6, 'h0E);
    wr(4'd4, 8'hFE);
    dr(1'b1);
    chk("R6 data before wrap", int'(dataRdVal), 'hBBAA);

    // R10 R11 events and mask
    wr(4'd8, 8'h40);
    evtSet = 7'h01; @(negedge clk); evtSet = 0;
    #1 chk("R11 masked event", int'(irq), 0);
    wr(4'd8, 8'h01);
    #1 chk("R11 enabled event", int'(irq), 1);
    evtSet = 7'h01; wr(4'd3, 8'h01); evtSet = 0;
    chkReg("R10 set wins", 4'd3, 'h01);
    wr(4'd3, 8'h01);
    chkReg("R10 cleared", 4'd3, 0);
    chk("R11 irq low", int'(irq), 0);

    // R12 page 1
    wr(4'd0, 8'h62);
    chkReg("R2 cmd readback", 4'd0, 'h62);
    chkReg("R12 first page", 4'd1, 'h02);
    chkReg("R12 last page", 4'd2, 'h03);
    chkReg("R12 mask", 4'd8, 'h01);
    wr(4'd8, 8'h00);
    wr(4'd1, 8'h07);
    chkReg("R12 mask write ignored", 4'd8, 'h01);
    chkReg("R12 page write ignored", 4'd1, 'h02);

    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule